// File: doc/BRIEF.md
# Latched Interrupt Status Controller

This block gathers single-cycle event pulses from receive, transmit and system-error sources into a 32-bit sticky status word. A mask word and a one-bit global enable produce a level interrupt request. Software reaches the block through a small register port: status is read-only and is cleared by the act of reading it, while mask and enable are read/write.

Only specific bit positions take events. One bit, 15, is not an event at all: it summarises the system-error group held in bits 16 to 25, so a single mask bit can cover that whole group. An event that arrives in the same cycle as a clearing read is not lost. It is held for the following read.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset the status, mask and enable registers are zero, `irq` is low and `reg_rdata` is zero.
- R2: An event pulse on an implemented bit of `ev_pulse` sets that status bit at the next clock edge. The bit stays set until status is read, and further pulses only add bits.
- R3: Implemented event bits are 0 to 14, 16 and 20 to 25. Events at bits 15, 17 to 19 and 26 to 31 are ignored. Bits 17 to 19 and 26 to 31 of status always read as zero.
- R4: Status bit 15 reads as the OR of status bits 16 to 25.
- R5: A read strobe at offset 0x10 puts the status value of that cycle on `reg_rdata` after the next clock edge. The same edge clears status.
- R6: An event in the same cycle as a clearing read does not appear in that read's data, but it is latched and returned by the next read.
- R7: A write to offset 0x10 has no effect on status.
- R8: The mask register at offset 0x14 stores and reads back all 32 bits. The enable register at offset 0x18 stores bit 0 only, and its bits 31 to 1 read as zero.
- R9: `irq` is high exactly when enable bit 0 is set and (status AND mask) is nonzero, with status including bit 15. It changes in the cycle after the clock edge that updates the register concerned.
- R10: Reads at offsets 0x14 or 0x18, and reads at any unmapped offset, leave status unchanged. An unmapped read returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_pulse | input | 32 | Event pulses, one per status bit position |
| reg_addr | input | 8 | Register byte offset |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered, held until the next read |
| irq | output | 1 | Level interrupt request |

## Verification
If a status bit is lost or sticks in the latch, the next status read shows it wrong, one cycle after the read strobe. If the latch fails to clear, the read that follows returns stale bits. A bad mask or enable value shows on `irq` in the cycle after the triggering edge, and also when that register is read back. The same-cycle read-and-event case is driven on purpose, because a faulty clear priority drops the event without any other visible sign.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;

    localparam int STAT_W = 32;

    // positions that accept event pulses
    localparam logic [STAT_W-1:0] SRC_BITS = 32'h03F1_7FFF;
    // positions folded into the summary bit
    localparam logic [STAT_W-1:0] SUM_SRC  = 32'h03FF_0000;
    localparam int                SUM_POS  = 15;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_STAT,
        SEL_MASK,
        SEL_EN
    } reg_sel_e;

    typedef struct packed {
        logic     rd;
        logic     wr;
        reg_sel_e sel;
    } reg_req_t;

    // software-visible status: stored source bits plus summary
    function automatic logic [STAT_W-1:0] status_view(input logic [STAT_W-1:0] stored);
        logic [STAT_W-1:0] v;
        v          = stored & SRC_BITS;
        v[SUM_POS] = |(stored & SUM_SRC);
        return v;
    endfunction

endpackage

// File: rtl/irq_event_latch.sv
module irq_event_latch
    import irq_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [STAT_W-1:0] ev,
    input  logic              clr,
    output logic [STAT_W-1:0] stat_q
);
    logic [STAT_W-1:0] base;

    // a clearing read drops old bits but keeps the new events
    always_comb base = clr ? '0 : stat_q;

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= base | (ev & SRC_BITS);
    end
endmodule

// File: rtl/irq_ctl_regs.sv
module irq_ctl_regs
    import irq_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  reg_req_t          req,
    input  logic [STAT_W-1:0] wdata,
    output logic [STAT_W-1:0] mask_q,
    output logic              en_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            en_q   <= 1'b0;
        end else if (req.wr) begin
            if (req.sel == SEL_MASK) mask_q <= wdata;
            if (req.sel == SEL_EN)   en_q   <= wdata[0];
        end
    end
endmodule

// File: rtl/irq_readmux.sv
module irq_readmux
    import irq_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  reg_req_t          req,
    input  logic [STAT_W-1:0] stat_view,
    input  logic [STAT_W-1:0] mask_q,
    input  logic              en_q,
    output logic [STAT_W-1:0] rdata_q
);
    logic [STAT_W-1:0] sel_data;

    always_comb begin
        unique case (req.sel)
            SEL_STAT: sel_data = stat_view;
            SEL_MASK: sel_data = mask_q;
            SEL_EN:   sel_data = {{(STAT_W-1){1'b0}}, en_q};
            default:  sel_data = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata_q <= '0;
        else if (req.rd) rdata_q <= sel_data;
    end
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
    import irq_stat_pkg::*;
#(
    parameter int               ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] OFS_STAT = 8'h10,
    parameter logic [ADDR_W-1:0] OFS_MASK = 8'h14,
    parameter logic [ADDR_W-1:0] OFS_EN   = 8'h18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [STAT_W-1:0] ev_pulse,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [STAT_W-1:0] reg_wdata,
    output logic [STAT_W-1:0] reg_rdata,
    output logic              irq
);
    reg_req_t          req;
    logic [STAT_W-1:0] stat_q;
    logic [STAT_W-1:0] stat_v;
    logic [STAT_W-1:0] mask_q;
    logic              en_q;
    logic              clr_stat;

    always_comb begin
        req.rd = reg_rd;
        req.wr = reg_wr;
        if      (reg_addr == OFS_STAT) req.sel = SEL_STAT;
        else if (reg_addr == OFS_MASK) req.sel = SEL_MASK;
        else if (reg_addr == OFS_EN)   req.sel = SEL_EN;
        else                           req.sel = SEL_NONE;
    end

    assign clr_stat = req.rd && (req.sel == SEL_STAT);

    irq_event_latch u_latch (
        .clk    (clk),
        .rst    (rst),
        .ev     (ev_pulse),
        .clr    (clr_stat),
        .stat_q (stat_q)
    );

    assign stat_v = status_view(stat_q);

    irq_ctl_regs u_ctl (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .wdata  (reg_wdata),
        .mask_q (mask_q),
        .en_q   (en_q)
    );

    irq_readmux u_rd (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .stat_view (stat_v),
        .mask_q    (mask_q),
        .en_q      (en_q),
        .rdata_q   (reg_rdata)
    );

    assign irq = en_q & (|(stat_v & mask_q));
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk
    import irq_stat_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              clr_stat,
    input logic              rd_en_reg,
    input logic [STAT_W-1:0] ev_pulse,
    input logic [STAT_W-1:0] stat_q,
    input logic [STAT_W-1:0] mask_q,
    input logic              en_q,
    input logic [STAT_W-1:0] reg_rdata,
    input logic              irq
);
    assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (rst)
        $past(clr_stat) |-> ((reg_rdata & 32'hFC0E_0000) == '0));

    assert_summary_R4: assert property (@(posedge clk) disable iff (rst)
        $past(clr_stat) |-> (reg_rdata[15] == (|reg_rdata[25:16])));

    assert_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        !clr_stat |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

    assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (clr_stat && ((ev_pulse & SRC_BITS) == '0)) |=> (stat_q == '0));

    assert_enable_read_R8: assert property (@(posedge clk) disable iff (rst)
        $past(rd_en_reg) |-> (reg_rdata[31:1] == '0));

    assert_irq_gate_R9: assert property (@(posedge clk) disable iff (rst)
        (!en_q || (mask_q == '0)) |-> !irq);
endmodule

bind irq_status_ctrl irq_status_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .clr_stat  (clr_stat),
    .rd_en_reg (req.rd && (req.sel == irq_stat_pkg::SEL_EN)),
    .ev_pulse  (ev_pulse),
    .stat_q    (stat_q),
    .mask_q    (mask_q),
    .en_q      (en_q),
    .reg_rdata (reg_rdata),
    .irq       (irq)
);

// File: tb/irq_status_ctrl_test.sv
module irq_status_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] ev_pulse = '0;
    logic [7:0]  reg_addr = '0;
    logic        reg_rd = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    irq_status_ctrl uut (
        .clk(clk), .rst(rst), .ev_pulse(ev_pulse), .reg_addr(reg_addr),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic [31:0] ev);
        @(negedge clk); ev_pulse = ev;
        @(negedge clk); ev_pulse = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; reg_rd = 1'b1;
        @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk); reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 rdata", reg_rdata, 32'h0);
        rd(8'h10, d); chk("R1 status", d, 32'h0);
        rd(8'h14, d); chk("R1 mask", d, 32'h0);
        rd(8'h18, d); chk("R1 enable", d, 32'h0);
    endtask

    task automatic t_latch();
        logic [31:0] d;
        pulse(32'h1);
        repeat (3) @(negedge clk);
        pulse(32'h80);
        rd(8'h10, d); chk("R2 sticky accumulate", d, 32'h81);
        rd(8'h10, d); chk("R5 cleared by read", d, 32'h0);
    endtask

    task automatic t_bitmap();
        logic [31:0] d;
        pulse(32'hFFFF_FFFF);
        rd(8'h10, d); chk("R3 implemented bits", d, 32'h03F1_FFFF);
        pulse(32'hFC0E_8000);
        rd(8'h10, d); chk("R3 unimplemented ignored", d, 32'h0);
    endtask

    task automatic t_summary();
        logic [31:0] d;
        pulse(32'h0040_0000);
        rd(8'h10, d); chk("R4 summary from bit 22", d, 32'h0040_8000);
        pulse(32'h20);
        rd(8'h10, d); chk("R4 no summary for low bit", d, 32'h20);
    endtask

    task automatic t_same_cycle();
        logic [31:0] d;
        pulse(32'h8);
        @(negedge clk); reg_addr = 8'h10; reg_rd = 1'b1; ev_pulse = 32'h200;
        @(negedge clk); reg_rd = 1'b0; ev_pulse = '0; d = reg_rdata;
        chk("R6 read excludes same-cycle event", d, 32'h8);
        rd(8'h10, d); chk("R6 same-cycle event kept", d, 32'h200);
    endtask

    task automatic t_nowrite();
        logic [31:0] d;
        pulse(32'h4);
        wr(8'h10, 32'hFFFF_FFFF);
        wr(8'h10, 32'h0);
        rd(8'h10, d); chk("R7 write to status ignored", d, 32'h4);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        wr(8'h14, 32'hA5A5_5A5A);
        rd(8'h14, d); chk("R8 mask readback", d, 32'hA5A5_5A5A);
        wr(8'h18, 32'hFFFF_FFFE);
        rd(8'h18, d); chk("R8 enable bit0 only clear", d, 32'h0);
        wr(8'h18, 32'hFFFF_FFFF);
        rd(8'h18, d); chk("R8 enable upper bits zero", d, 32'h1);
        wr(8'h18, 32'h0);
        wr(8'h14, 32'h0);
        pulse(32'h2);
        rd(8'h14, d);
        rd(8'h18, d);
        rd(8'h1C, d); chk("R10 unmapped read zero", d, 32'h0);
        rd(8'h10, d); chk("R10 other reads keep status", d, 32'h2);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        wr(8'h14, 32'h40);
        wr(8'h18, 32'h1);
        pulse(32'h1);
        chk("R9 unmasked event no irq", {31'b0, irq}, 32'h0);
        @(negedge clk); ev_pulse = 32'h40;
        @(negedge clk); ev_pulse = '0;
        chk("R9 irq next cycle", {31'b0, irq}, 32'h1);
        wr(8'h18, 32'h0);
        chk("R9 enable off", {31'b0, irq}, 32'h0);
        wr(8'h18, 32'h1);
        chk("R9 enable on", {31'b0, irq}, 32'h1);
        rd(8'h10, d); chk("R9 status at irq", d, 32'h41);
        chk("R9 irq drops after clear", {31'b0, irq}, 32'h0);
        wr(8'h14, 32'h8000);
        pulse(32'h0080_0000);
        chk("R9 summary bit drives irq", {31'b0, irq}, 32'h1);
        rd(8'h10, d); chk("R4 summary read", d, 32'h0080_8000);
        chk("R9 irq low after summary clear", {31'b0, irq}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_latch();
        t_bitmap();
        t_summary();
        t_same_cycle();
        t_nowrite();
        t_regs();
        t_irq();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule